// File: doc/BRIEF.md
# Two-Port Bridge Address Filter with Learning and Aging

This block decides, for every frame arriving on either port of a two-port transparent bridge, whether the frame is passed to the other port or dropped as local traffic. Each port's receive path gives it a capture strobe with the destination address as soon as that address has arrived. One cycle later the block returns a decision for that port. The same receive path gives an end-of-frame strobe with the source address and two flags: the frame was good, and the frame was unicast. On that strobe the block records the source address against the port the frame came in on.

The station table is direct-mapped. Its depth is a parameter, and 2048 entries is the default. Each slot holds an address, a port number, a valid bit and an age mark. A background scheduler walks the slots in index order, one slot per step. The number of clock cycles in a step is a parameter. The default step, with a 50 MHz clock, gives a full sweep of 150 s, so a station that stays silent is removed after 300 s.

The scheduler is a two-state machine. AG_WAIT counts cycles. It moves to AG_VISIT when the step counter reaches its last value (transition STEP_DONE). AG_VISIT handles one slot and always returns to AG_WAIT on the next cycle (transition VISIT_DONE). Reset puts the machine in AG_WAIT with the count and the slot pointer both at zero.

Top module: `bridge_filter`

## Requirements
- R1: After reset, no decision is valid and the table is empty, so any unicast destination looked up on either port is forwarded.
- R2: A capture strobe on port p in one cycle gives dec_vld[p] high for exactly the following cycle. dec_fwd[p] is valid in that cycle.
- R3: If the destination is valid in the table with the same full 48-bit address and was learned on the receiving port, the decision is drop (dec_fwd = 0).
- R4: A destination that is not in the table, or that was learned on the other port, is forwarded (dec_fwd = 1).
- R5: A destination with its group bit set (bit 40 of the 48-bit value, whose first octet is bits 47:40) is always forwarded, even if that address was learned on the receiving port.
- R6: A source address is written only when the end-of-frame strobe arrives with both frm_good and frm_ucast high. Any other end-of-frame strobe leaves the table unchanged.
- R7: The slot index is the low IDX_W address bits XOR the next IDX_W bits. A new source address replaces whatever entry already occupies its slot.
- R8: Aging visits one slot every AGE_STEP_CYCLES cycles, starting at slot 0 and wrapping at the end of the table. The visits land on the AGE_STEP_CYCLES-th, 2·AGE_STEP_CYCLES-th, … clock edge after reset is released. A visit marks a valid unmarked entry and invalidates a valid marked entry.
- R9: Learning an address clears its age mark. If a learn and an aging visit address the same slot on the same edge, the learn wins and the entry stays valid and unmarked.
- R10: If both ports learn into the same slot on the same edge, the port 0 entry is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| da_stb | input | 2 | Per-port destination-captured strobe |
| da_mac | input | 2x48 | Per-port destination address |
| eof_stb | input | 2 | Per-port end-of-frame strobe |
| sa_mac | input | 2x48 | Per-port source address |
| frm_good | input | 2 | Frame passed its receive checks |
| frm_ucast | input | 2 | Frame was unicast |
| dec_vld | output | 2 | Per-port decision valid |
| dec_fwd | output | 2 | 1 = forward to the other port, 0 = drop |

## Verification
The bench builds the block with IDX_W = 4 (16 slots) and AGE_STEP_CYCLES = 4. A full aging sweep therefore takes 64 cycles, and an idle entry is removed well inside 150 cycles. These values bring the following cases within a short run: slot collisions, same-slot learning from both ports, removal of an idle entry, and a learn landing on the very edge where the scheduler visits a marked slot.

// File: rtl/bf_pkg.sv
package bf_pkg;
    localparam int MAC_W   = 48;
    localparam int GRP_BIT = 40;
    localparam int NPORT   = 2;

    typedef logic [MAC_W-1:0] mac_t;

    typedef enum logic {
        AG_WAIT  = 1'b0,
        AG_VISIT = 1'b1
    } age_state_e;
endpackage

// File: rtl/bf_age_sched.sv
module bf_age_sched
    import bf_pkg::*;
#(
    parameter int IDX_W           = 11,
    parameter int AGE_STEP_CYCLES = 3662109
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             visit,
    output logic [IDX_W-1:0] vptr
);
    localparam int CNT_W = (AGE_STEP_CYCLES > 2) ? $clog2(AGE_STEP_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(AGE_STEP_CYCLES - 2);

    age_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= AG_WAIT;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            AG_WAIT:  st_d = (cnt_q == CNT_LAST) ? AG_VISIT : AG_WAIT;
            AG_VISIT: st_d = AG_WAIT;
            default:  st_d = AG_WAIT;
        endcase
    end

    always_comb begin
        visit = (st_q == AG_VISIT);
        vptr  = ptr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ptr_q <= '0;
        end else begin
            if (st_q == AG_WAIT) cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
            if (st_q == AG_VISIT) ptr_q <= ptr_q + 1'b1;
        end
    end

    // R8
    visit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == AG_VISIT) |=> (st_q == AG_WAIT));
    // R8
    ptr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == AG_VISIT) |=> (ptr_q == $past(ptr_q) + 1'b1));
    // R8
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST);
endmodule

// File: rtl/bf_table.sv
module bf_table
    import bf_pkg::*;
#(
    parameter int IDX_W = 11
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   visit,
    input  logic [IDX_W-1:0]       vptr,
    input  logic [NPORT-1:0]       lrn_en,
    input  logic [NPORT-1:0][MAC_W-1:0] lrn_mac,
    input  logic [NPORT-1:0][MAC_W-1:0] rd_mac,
    output logic [NPORT-1:0]       rd_vld,
    output logic [NPORT-1:0][MAC_W-1:0] rd_ent,
    output logic [NPORT-1:0]       rd_port
);
    localparam int DEPTH = 1 << IDX_W;

    logic vld_q  [DEPTH];
    logic age_q  [DEPTH];
    logic port_q [DEPTH];
    mac_t mac_q  [DEPTH];

    logic [NPORT-1:0][IDX_W-1:0] wr_idx;
    logic [NPORT-1:0][IDX_W-1:0] rd_idx;

    function automatic logic [IDX_W-1:0] slot_of(input mac_t m);
        return m[IDX_W-1:0] ^ m[2*IDX_W-1:IDX_W];
    endfunction

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            wr_idx[p]  = slot_of(lrn_mac[p]);
            rd_idx[p]  = slot_of(rd_mac[p]);
            rd_vld[p]  = vld_q[rd_idx[p]];
            rd_ent[p]  = mac_q[rd_idx[p]];
            rd_port[p] = port_q[rd_idx[p]];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                vld_q[i] <= 1'b0;
                age_q[i] <= 1'b0;
            end
        end else begin
            if (visit && vld_q[vptr]) begin
                if (age_q[vptr]) vld_q[vptr] <= 1'b0;
                else             age_q[vptr] <= 1'b1;
            end
            for (int p = NPORT - 1; p >= 0; p--) begin
                if (lrn_en[p]) begin
                    vld_q[wr_idx[p]] <= 1'b1;
                    age_q[wr_idx[p]] <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (lrn_en[p]) begin
                mac_q[wr_idx[p]]  <= lrn_mac[p];
                port_q[wr_idx[p]] <= 1'(p);
            end
        end
    end

    // R10
    port0_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lrn_en[0] |=> (vld_q[$past(wr_idx[0])] && !port_q[$past(wr_idx[0])]
                       && mac_q[$past(wr_idx[0])] == $past(lrn_mac[0])));
    // R8
    age_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (visit && vld_q[vptr] && age_q[vptr]
         && !(lrn_en[0] && wr_idx[0] == vptr) && !(lrn_en[1] && wr_idx[1] == vptr))
        |=> !vld_q[$past(vptr)]);
endmodule

// File: rtl/bf_decide.sv
module bf_decide
    import bf_pkg::*;
#(
    parameter int PORT_ID = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic da_stb,
    input  mac_t da_mac,
    input  logic ent_vld,
    input  mac_t ent_mac,
    input  logic ent_port,
    output logic dec_vld,
    output logic dec_fwd
);
    logic local_hit;

    always_comb
        local_hit = !da_mac[GRP_BIT] && ent_vld && (ent_mac == da_mac)
                    && (ent_port == 1'(PORT_ID));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_vld <= 1'b0;
            dec_fwd <= 1'b0;
        end else begin
            dec_vld <= da_stb;
            if (da_stb) dec_fwd <= !local_hit;
        end
    end

    // R5
    grp_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (da_stb && da_mac[GRP_BIT]) |=> (dec_vld && dec_fwd));
endmodule

// File: rtl/bridge_filter.sv
module bridge_filter
    import bf_pkg::*;
#(
    parameter int IDX_W           = 11,
    parameter int AGE_STEP_CYCLES = 3662109
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            da_stb,
    input  logic [1:0][47:0]      da_mac,
    input  logic [1:0]            eof_stb,
    input  logic [1:0][47:0]      sa_mac,
    input  logic [1:0]            frm_good,
    input  logic [1:0]            frm_ucast,
    output logic [1:0]            dec_vld,
    output logic [1:0]            dec_fwd
);
    logic                         visit;
    logic [IDX_W-1:0]             vptr;
    logic [NPORT-1:0]             lrn_en;
    logic [NPORT-1:0]             rd_vld;
    logic [NPORT-1:0][MAC_W-1:0]  rd_ent;
    logic [NPORT-1:0]             rd_port;

    always_comb lrn_en = eof_stb & frm_good & frm_ucast;

    bf_age_sched #(.IDX_W(IDX_W), .AGE_STEP_CYCLES(AGE_STEP_CYCLES)) u_sched (
        .clk(clk), .rst_n(rst_n), .visit(visit), .vptr(vptr)
    );

    bf_table #(.IDX_W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n), .visit(visit), .vptr(vptr),
        .lrn_en(lrn_en), .lrn_mac(sa_mac), .rd_mac(da_mac),
        .rd_vld(rd_vld), .rd_ent(rd_ent), .rd_port(rd_port)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        bf_decide #(.PORT_ID(p)) u_dec (
            .clk(clk), .rst_n(rst_n),
            .da_stb(da_stb[p]), .da_mac(da_mac[p]),
            .ent_vld(rd_vld[p]), .ent_mac(rd_ent[p]), .ent_port(rd_port[p]),
            .dec_vld(dec_vld[p]), .dec_fwd(dec_fwd[p])
        );
    end
endmodule

// File: tb/bridge_filter_bench.sv
module bridge_filter_bench;
    localparam int IDX_W = 4;
    localparam int DEPTH = 1 << IDX_W;
    localparam int STEP  = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      da_stb = '0;
    logic [1:0][47:0] da_mac = '0;
    logic [1:0]      eof_stb = '0;
    logic [1:0][47:0] sa_mac = '0;
    logic [1:0]      frm_good = '0;
    logic [1:0]      frm_ucast = '0;
    logic [1:0]      dec_vld;
    logic [1:0]      dec_fwd;

    bridge_filter #(.IDX_W(IDX_W), .AGE_STEP_CYCLES(STEP)) u_bridge_filter (
        .clk(clk), .rst_n(rst_n), .da_stb(da_stb), .da_mac(da_mac),
        .eof_stb(eof_stb), .sa_mac(sa_mac), .frm_good(frm_good),
        .frm_ucast(frm_ucast), .dec_vld(dec_vld), .dec_fwd(dec_fwd)
    );

    always #2 clk = ~clk;

    // reference model state
    bit          mv [DEPTH];
    bit          mg [DEPTH];
    int          mp [DEPTH];
    logic [47:0] ma [DEPTH];
    int          edge_n = 0;
    int          aptr = 0;
    bit [1:0]    exp_vld = '0;
    bit [1:0]    exp_fwd = '0;
    string       why [2] = '{"R1", "R1"};
    string       cur_req = "R1";
    int          n_chk = 0, n_err = 0, cyc = 0;

    function automatic int slot_of(input logic [47:0] m);
        return int'(m[3:0] ^ m[7:4]);
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d at t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin mv[i] = 0; mg[i] = 0; end
            edge_n = 0; aptr = 0; exp_vld = '0;
        end else begin
            for (int p = 0; p < 2; p++) begin
                exp_vld[p] = da_stb[p];
                if (da_stb[p]) begin
                    int s = slot_of(da_mac[p]);
                    if (da_mac[p][40]) begin exp_fwd[p] = 1; why[p] = "R5"; end
                    else if (mv[s] && ma[s] == da_mac[p] && mp[s] == p) begin exp_fwd[p] = 0; why[p] = "R3"; end
                    else begin exp_fwd[p] = 1; why[p] = "R4"; end
                end
            end
            edge_n++;
            if (edge_n % STEP == 0) begin
                if (mv[aptr]) begin
                    if (mg[aptr]) mv[aptr] = 0; else mg[aptr] = 1;
                end
                aptr = (aptr + 1) % DEPTH;
            end
            for (int p = 1; p >= 0; p--) begin
                if (eof_stb[p] && frm_good[p] && frm_ucast[p]) begin
                    int s = slot_of(sa_mac[p]);
                    mv[s] = 1; mg[s] = 0; mp[s] = p; ma[s] = sa_mac[p];
                end
            end
        end
        if (cyc > 150000) begin
            n_chk++; n_err++;
            $display("FAIL %s watchdog actual=%0d expected=%0d", cur_req, cyc, 150000);
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < 2; p++) begin
                check(dec_vld[p] == exp_vld[p], cur_req, "R2 dec_vld", int'(dec_vld[p]), int'(exp_vld[p]));
                if (exp_vld[p])
                    check(dec_fwd[p] == exp_fwd[p], cur_req, {why[p], " dec_fwd"}, int'(dec_fwd[p]), int'(exp_fwd[p]));
            end
        end
    end

    task automatic look(input int p, input logic [47:0] m);
        da_stb[p] = 1'b1; da_mac[p] = m;
        @(negedge clk);
        da_stb[p] = 1'b0;
        @(negedge clk);
    endtask

    task automatic learn(input int p, input logic [47:0] m, input bit g, input bit u);
        eof_stb[p] = 1'b1; sa_mac[p] = m; frm_good[p] = g; frm_ucast[p] = u;
        @(negedge clk);
        eof_stb[p] = 1'b0;
    endtask

    task automatic wait_visit(input int s);
        do @(negedge clk);
        while (!(((edge_n + 1) % STEP == 0) && ((((edge_n + 1) / STEP) - 1) % DEPTH == s)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(dec_vld == 2'b00, "R1", "dec_vld in reset", int'(dec_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dec_vld == 2'b00, "R1", "dec_vld after reset", int'(dec_vld), 0);
        cur_req = "R1";
        look(0, 48'h0200_0000_0012);
        look(1, 48'h0200_0000_0012);
        // R6 learn and R3/R4 lookups
        cur_req = "R6";
        learn(0, 48'h0200_0000_0012, 1, 1);
        cur_req = "R3";
        look(0, 48'h0200_0000_0012);
        cur_req = "R4";
        look(1, 48'h0200_0000_0012);
        look(0, 48'h0200_0000_0055);
        // R6: bad or non-unicast frames do not learn
        cur_req = "R6";
        learn(1, 48'h0200_0000_0044, 0, 1);
        look(1, 48'h0200_0000_0044);
        learn(1, 48'h0200_0000_0066, 1, 0);
        look(1, 48'h0200_0000_0066);
        // R5: group address learned locally still forwarded
        cur_req = "R5";
        learn(0, 48'h0300_0000_0077, 1, 1);
        look(0, 48'h0300_0000_0077);
        // R7: same slot replaces previous entry
        cur_req = "R7";
        learn(1, 48'h0200_0000_0021, 1, 1);
        look(0, 48'h0200_0000_0012);
        look(1, 48'h0200_0000_0021);
        // R10: both ports into one slot on one edge
        cur_req = "R10";
        eof_stb = 2'b11; frm_good = 2'b11; frm_ucast = 2'b11;
        sa_mac[0] = 48'h0200_0000_0030; sa_mac[1] = 48'h0200_0000_0003;
        @(negedge clk);
        eof_stb = 2'b00;
        look(0, 48'h0200_0000_0030);
        look(1, 48'h0200_0000_0003);
        // R8: idle entry removed after two visits
        cur_req = "R8";
        learn(1, 48'h0200_0000_00a5, 1, 1);
        look(1, 48'h0200_0000_00a5);
        repeat (70) @(negedge clk);
        look(1, 48'h0200_0000_00a5);
        repeat (70) @(negedge clk);
        look(1, 48'h0200_0000_00a5);
        // R9: learn lands on the visit of a marked slot
        cur_req = "R9";
        learn(1, 48'h0200_0000_00c4, 1, 1);
        wait_visit(slot_of(48'h0200_0000_00c4));
        wait_visit(slot_of(48'h0200_0000_00c4));
        learn(1, 48'h0200_0000_00c4, 1, 1);
        look(1, 48'h0200_0000_00c4);
        repeat (40) @(negedge clk);
        look(1, 48'h0200_0000_00c4);
        repeat (4) @(negedge clk);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule